// File: doc/BRIEF.md
# Banked Interrupt Controller With Shortcut Summary

This block gathers 72 level-sensitive interrupt sources into one IRQ line and one FIQ line for a processor core. Sixty-four peripheral sources sit in two 32-bit banks. Eight core-local sources sit in a small local bank. Each source has its own enable bit. Software changes an enable only by writing ones to a set address or to a clear address. It never writes the mask directly, so two agents can change different bits without a read-modify-write race.

A summary word puts what software needs first in a single read:
- the eight local pending bits;
- one "anything pending" flag for each peripheral bank;
- copies of eleven frequently used peripheral lines.

A fast-interrupt control register can pick any one source and send it to FIQ instead of IRQ. Every input passes through a two-stage synchroniser before it reaches the pending logic.

Software reaches the registers over a simple single-cycle bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `irqc_top`

## Requirements
- R1: After reset every enable bit is 0, the fast-interrupt control register is 0, and both irq_o and fiq_o are low.
- R2: A write to a set address (word 0x4 for peripheral lines 0–31, 0x5 for lines 32–63, 0x6 for local lines) sets each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to a clear address (0x7 for lines 0–31, 0x8 for lines 32–63, 0x9 for local lines) clears each enable bit whose data bit is 1. Reading either the set address or the clear address of a bank returns that bank's current enable mask.
- R4: Source number n below 64 is bit n&31 of peripheral bank n>>5. Sources 64–71 are local lines 0–7.
- R5: A pending bit equals the synchronised input AND its enable. A change on an input shows in the pending bits and in the outputs after the second rising clock edge that follows it, and not after the first.
- R6: The summary word at address 0x0 carries local pending bits in bits 0–7. Bit 8 is the OR of all bank-1 pending bits (word 0x1). Bit 9 is the OR of all bank-2 pending bits (word 0x2).
- R7: Summary bits 10 to 20 copy the pending bits of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Bits 21–31 read 0.
- R8: irq_o is the OR of all pending bits, leaving out the one source routed to FIQ.
- R9: The fast-interrupt control register sits at word 0x3 and reads back as its 8 bits. Bit 7 enables routing and bits 6:0 give the source number. fiq_o is high only when routing is enabled, the source number is below 72, and that source's synchronised input is high, whatever its enable bit.
- R10: Writes to words 0x0–0x2 change no enable. Addresses 0xA–0xF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| periph_irq_i | input | 64 | Peripheral interrupt levels, sources 0–63 |
| local_irq_i | input | 8 | Core-local interrupt levels, sources 64–71 |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during a read access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: two 32-bit peripheral banks, eight local lines and two synchroniser stages. With these values all eleven shortcut copies fall inside real lines, including line 62 near the top of bank 2. The 7-bit source field can also name numbers from 72 to 127, which have no source behind them, so the bench can check that such selections leave FIQ silent. The two-stage depth lets the bench check that a change is absent after the first edge and present after the second.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int REG_ADDR_W = 4;
  localparam int SC_COUNT   = 11;

  localparam logic [REG_ADDR_W-1:0] RA_SUMMARY = 4'h0;
  localparam logic [REG_ADDR_W-1:0] RA_PEND_LO = 4'h1;
  localparam logic [REG_ADDR_W-1:0] RA_PEND_HI = 4'h2;
  localparam logic [REG_ADDR_W-1:0] RA_FIQ_CTL = 4'h3;
  localparam logic [REG_ADDR_W-1:0] RA_SET_LO  = 4'h4;
  localparam logic [REG_ADDR_W-1:0] RA_SET_HI  = 4'h5;
  localparam logic [REG_ADDR_W-1:0] RA_SET_LOC = 4'h6;
  localparam logic [REG_ADDR_W-1:0] RA_CLR_LO  = 4'h7;
  localparam logic [REG_ADDR_W-1:0] RA_CLR_HI  = 4'h8;
  localparam logic [REG_ADDR_W-1:0] RA_CLR_LOC = 4'h9;

  // Peripheral line copied into shortcut slot i of the summary word.
  function automatic int sc_line(input int i);
    case (i)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      4:       return 19;
      5:       return 53;
      6:       return 54;
      7:       return 55;
      8:       return 56;
      9:       return 57;
      default: return 62;
    endcase
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d_i;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] en_q;
  logic [W-1:0] en_d;
  logic         en_upd;

  always_comb begin
    en_upd = (|set_i) | (|clr_i);
    en_d   = (en_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  assign en_o   = en_q;
  assign pend_o = raw_i & en_q;

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0 && clr_i == '0) |=> ((en_q & $past(set_i)) == $past(set_i)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((en_q & $past(clr_i)) == '0));

  // R2
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(en_q));

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
#(
  parameter int BANK_W  = 32,
  parameter int LOCAL_N = 8,
  parameter int DATA_W  = 32
) (
  input  logic [BANK_W-1:0]   pend_lo_i,
  input  logic [BANK_W-1:0]   pend_hi_i,
  input  logic [LOCAL_N-1:0]  pend_loc_i,
  output logic [DATA_W-1:0]   word_o
);

  localparam int SC_BASE  = LOCAL_N + 2;
  localparam int USED_W   = SC_BASE + SC_COUNT;

  logic [2*BANK_W-1:0] periph_pend;
  logic [SC_COUNT-1:0] sc_bits;

  assign periph_pend = {pend_hi_i, pend_lo_i};

  for (genvar i = 0; i < SC_COUNT; i++) begin : g_sc
    localparam int LINE = sc_line(i);
    assign sc_bits[i] = periph_pend[LINE];
  end

  always_comb begin
    word_o = '0;
    word_o[LOCAL_N-1:0]          = pend_loc_i;
    word_o[LOCAL_N]              = |pend_lo_i;
    word_o[LOCAL_N+1]            = |pend_hi_i;
    word_o[USED_W-1:SC_BASE]     = sc_bits;
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int BANK_W      = 32,
  parameter int LOCAL_N     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*BANK_W-1:0]   periph_irq_i,
  input  logic [LOCAL_N-1:0]    local_irq_i,
  input  logic                  bus_sel_i,
  input  logic                  bus_we_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [BANK_W-1:0]     bus_wdata_i,
  output logic [BANK_W-1:0]     bus_rdata_o,
  output logic                  irq_o,
  output logic                  fiq_o
);

  localparam int DATA_W  = BANK_W;
  localparam int NUM_SRC = 2*BANK_W + LOCAL_N;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int FIQ_W   = SEL_W + 1;

  logic [NUM_SRC-1:0] raw_sync;
  logic [BANK_W-1:0]  pb_set [2];
  logic [BANK_W-1:0]  pb_clr [2];
  logic [BANK_W-1:0]  pb_en  [2];
  logic [BANK_W-1:0]  pb_pend[2];
  logic [LOCAL_N-1:0] loc_set, loc_clr, loc_en, loc_pend;
  logic [DATA_W-1:0]  summary;
  logic               wr_stb;
  logic               rd_stb;

  logic [FIQ_W-1:0]   fiq_q, fiq_d;
  logic               fiq_upd;
  logic [SEL_W-1:0]   fiq_sel;
  logic               fiq_on;
  logic [NUM_SRC-1:0] route_mask;
  logic [NUM_SRC-1:0] pend_all;
  logic               fiq_hit;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:FIQ_W];

  assign wr_stb = bus_sel_i & bus_we_i;
  assign rd_stb = bus_sel_i & ~bus_we_i;

  irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({local_irq_i, periph_irq_i}),
    .q_o   (raw_sync)
  );

  for (genvar b = 0; b < 2; b++) begin : g_pbank
    localparam logic [REG_ADDR_W-1:0] SET_A = RA_SET_LO + REG_ADDR_W'(b);
    localparam logic [REG_ADDR_W-1:0] CLR_A = RA_CLR_LO + REG_ADDR_W'(b);

    assign pb_set[b] = (wr_stb && bus_addr_i == SET_A) ? bus_wdata_i : '0;
    assign pb_clr[b] = (wr_stb && bus_addr_i == CLR_A) ? bus_wdata_i : '0;

    irqc_bank #(.W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pb_set[b]),
      .clr_i  (pb_clr[b]),
      .raw_i  (raw_sync[b*BANK_W +: BANK_W]),
      .en_o   (pb_en[b]),
      .pend_o (pb_pend[b])
    );
  end

  assign loc_set = (wr_stb && bus_addr_i == RA_SET_LOC) ? bus_wdata_i[LOCAL_N-1:0] : '0;
  assign loc_clr = (wr_stb && bus_addr_i == RA_CLR_LOC) ? bus_wdata_i[LOCAL_N-1:0] : '0;

  irqc_bank #(.W(LOCAL_N)) u_loc (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (loc_set),
    .clr_i  (loc_clr),
    .raw_i  (raw_sync[2*BANK_W +: LOCAL_N]),
    .en_o   (loc_en),
    .pend_o (loc_pend)
  );

  irqc_summary #(.BANK_W(BANK_W), .LOCAL_N(LOCAL_N), .DATA_W(DATA_W)) u_sum (
    .pend_lo_i  (pb_pend[0]),
    .pend_hi_i  (pb_pend[1]),
    .pend_loc_i (loc_pend),
    .word_o     (summary)
  );

  // Fast-interrupt control register: next state, then register.
  always_comb begin
    fiq_upd = wr_stb && (bus_addr_i == RA_FIQ_CTL);
    fiq_d   = bus_wdata_i[FIQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fiq_q <= '0;
    else if (fiq_upd) fiq_q <= fiq_d;
  end

  assign fiq_on  = fiq_q[SEL_W];
  assign fiq_sel = fiq_q[SEL_W-1:0];

  always_comb begin
    route_mask = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (fiq_on && fiq_sel == SEL_W'(i)) route_mask[i] = 1'b1;
    end
  end

  assign pend_all = {loc_pend, pb_pend[1], pb_pend[0]};
  assign fiq_hit  = |(route_mask & raw_sync);
  assign irq_o    = |(pend_all & ~route_mask);
  assign fiq_o    = fiq_hit;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_stb) begin
      case (bus_addr_i)
        RA_SUMMARY:             bus_rdata_o = summary;
        RA_PEND_LO:             bus_rdata_o = pb_pend[0];
        RA_PEND_HI:             bus_rdata_o = pb_pend[1];
        RA_FIQ_CTL:             bus_rdata_o = DATA_W'(fiq_q);
        RA_SET_LO, RA_CLR_LO:   bus_rdata_o = pb_en[0];
        RA_SET_HI, RA_CLR_HI:   bus_rdata_o = pb_en[1];
        RA_SET_LOC, RA_CLR_LOC: bus_rdata_o = DATA_W'(loc_en);
        default:                bus_rdata_o = '0;
      endcase
    end
  end

  // R9
  fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_on |-> !fiq_o);

  // R10
  pend_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && bus_addr_i <= RA_PEND_HI) |=>
      ($stable(pb_en[0]) && $stable(pb_en[1]) && $stable(loc_en)));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_all != '0));

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] periph;
  logic [7:0]  loc;
  logic        sel, we;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_run  = 0;
  int n_fail = 0;

  logic [31:0] m_en_lo, m_en_hi;
  logic [7:0]  m_en_loc;
  logic [7:0]  m_fiq;

  always #2.5 clk = ~clk;

  irqc_top dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .periph_irq_i (periph),
    .local_irq_i  (loc),
    .bus_sel_i    (sel),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .irq_o        (irq),
    .fiq_o        (fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FIAL-free marker");
    end
  endtask

  function automatic logic [71:0] exp_pend();
    return {loc & m_en_loc, periph[63:32] & m_en_hi, periph[31:0] & m_en_lo};
  endfunction

  function automatic logic [71:0] exp_route();
    logic [71:0] m = '0;
    if (m_fiq[7] && m_fiq[6:0] < 7'd72) m[m_fiq[6:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_summary();
    logic [71:0] p = exp_pend();
    logic [31:0] w = '0;
    int lines[11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
    w[7:0] = p[71:64];
    w[8]   = |p[31:0];
    w[9]   = |p[63:32];
    for (int i = 0; i < 11; i++) w[10+i] = p[lines[i]];
    return w;
  endfunction

  function automatic logic exp_fiq();
    logic [71:0] raw = {loc, periph};
    return |(exp_route() & raw);
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; we = 1'b0;
    case (a)
      4'h3: m_fiq = d[7:0];
      4'h4: m_en_lo  = m_en_lo  | d;
      4'h5: m_en_hi  = m_en_hi  | d;
      4'h6: m_en_loc = m_en_loc | d[7:0];
      4'h7: m_en_lo  = m_en_lo  & ~d;
      4'h8: m_en_hi  = m_en_hi  & ~d;
      4'h9: m_en_loc = m_en_loc & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    bus_rd(4'h0, d); chk({tag, " R6 R7 summary"}, d, exp_summary());
    bus_rd(4'h1, d); chk({tag, " R5 pend lo"}, d, periph[31:0] & m_en_lo);
    bus_rd(4'h2, d); chk({tag, " R4 pend hi"}, d, periph[63:32] & m_en_hi);
    bus_rd(4'h3, d); chk({tag, " R9 fiq ctl"}, d, {24'h0, m_fiq});
    bus_rd(4'h4, d); chk({tag, " R2 en lo"}, d, m_en_lo);
    bus_rd(4'h8, d); chk({tag, " R3 en hi via clr"}, d, m_en_hi);
    bus_rd(4'h9, d); chk({tag, " R3 en loc"}, d, {24'h0, m_en_loc});
    chk({tag, " R8 irq"}, {31'h0, irq}, {31'h0, |(exp_pend() & ~exp_route())});
    chk({tag, " R9 fiq"}, {31'h0, fiq}, {31'h0, exp_fiq()});
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: expired, act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lines[11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    periph = '0; loc = '0;
    m_en_lo = '0; m_en_hi = '0; m_en_loc = '0; m_fiq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    periph = '1; loc = '1;
    settle();

    // R1 reset state
    bus_rd(4'h4, d); chk("R1 en lo after reset", d, 32'h0);
    bus_rd(4'h5, d); chk("R1 en hi after reset", d, 32'h0);
    bus_rd(4'h6, d); chk("R1 en loc after reset", d, 32'h0);
    bus_rd(4'h3, d); chk("R1 fiq ctl after reset", d, 32'h0);
    chk("R1 irq low", {31'h0, irq}, 32'h0);
    chk("R1 fiq low", {31'h0, fiq}, 32'h0);

    // R2 / R3 set and clear with zero bits untouched
    periph = '0; loc = '0;
    bus_wr(4'h4, 32'hF0F0_00FF);
    bus_wr(4'h4, 32'h0000_0F00);
    bus_rd(4'h7, d); chk("R2 set accumulates", d, 32'hF0F0_0FFF);
    bus_wr(4'h7, 32'h8000_000F);
    bus_rd(4'h4, d); chk("R3 clear removes ones only", d, 32'h70F0_0FF0);

    // R4 source 40 lives in hi bank bit 8; local line 3 is source 67
    bus_wr(4'h5, 32'h0000_0100);
    bus_wr(4'h6, 32'h0000_0008);
    periph[40] = 1'b1; loc[3] = 1'b1;
    settle();
    bus_rd(4'h2, d); chk("R4 line 40 in hi bank bit 8", d, 32'h0000_0100);
    bus_rd(4'h0, d); chk("R4 R6 summary loc3 and hi flag", d, 32'h0000_0208);

    // R5 two-edge synchroniser latency
    periph[40] = 1'b0; loc[3] = 1'b0;
    settle();
    periph[4] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd(4'h1, d); chk("R5 not visible after first edge", d, 32'h0);
    @(posedge clk); @(negedge clk);
    bus_rd(4'h1, d); chk("R5 visible after second edge", d, 32'h0000_0010);
    chk("R8 irq from line 4", {31'h0, irq}, 32'h1);
    periph[4] = 1'b0;

    // R7 each shortcut line alone
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_wr(4'h5, 32'hFFFF_FFFF);
    for (int i = 0; i < 11; i++) begin
      periph = '0;
      periph[lines[i]] = 1'b1;
      settle();
      bus_rd(4'h0, d);
      chk("R7 shortcut slot", d, (32'h1 << (10 + i)) | (lines[i] < 32 ? 32'h100 : 32'h200));
    end

    // R9 route line 62 to FIQ, not IRQ
    bus_wr(4'h3, 32'h0000_00BE);
    settle();
    chk("R9 fiq on line 62", {31'h0, fiq}, 32'h1);
    chk("R8 irq excludes routed line", {31'h0, irq}, 32'h0);
    bus_wr(4'h7, 32'hFFFF_FFFF);
    bus_wr(4'h8, 32'hFFFF_FFFF);
    settle();
    chk("R9 fiq ignores enable", {31'h0, fiq}, 32'h1);
    bus_wr(4'h3, 32'h0000_00E4);
    loc = '1;
    settle();
    chk("R9 code 100 has no source", {31'h0, fiq}, 32'h0);
    bus_rd(4'h3, d); chk("R9 readback", d, 32'h0000_00E4);

    // R10 writes to pending words ignored; unmapped reads zero
    bus_wr(4'h6, 32'h0000_0005);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_wr(4'h1, 32'hFFFF_FFFF);
    bus_wr(4'h2, 32'hFFFF_FFFF);
    check_all("R10 after pend writes");
    bus_rd(4'hA, d); chk("R10 unmapped 0xA", d, 32'h0);
    bus_rd(4'hF, d); chk("R10 unmapped 0xF", d, 32'h0);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [3:0] a;
      logic [31:0] v;
      periph = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      loc    = 8'($urandom & $urandom);
      a = 4'($urandom_range(3, 9));
      v = $urandom & $urandom;
      if (a == 4'h3) v = {24'h0, 1'b1 & v[7], 7'($urandom_range(0, 80))};
      bus_wr(a, v);
      settle();
      check_all("rand");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(negedge clk) begin : report_unused
  end

endmodule